// File: doc/BRIEF.md
# Pipeline PC Shift Buffer

This block tracks the program counter of every instruction in flight in a five-stage in-order pipeline whose stage flip-flops are volatile. The fetch PC enters the first slot, and each cycle every entry moves one slot toward write-back, together with its own instruction. Per-stage stall and flush controls are honoured, so the pipeline controller can always read which PC occupies each stage and whether that stage holds a real instruction. Because each in-flight instruction carries its real PC, the saved address stays correct after taken jumps and branches, where subtracting from the fetch PC would give the wrong answer.

When a power-down request arrives, the instruction in write-back is allowed to retire. The PC in the memory stage is latched as the resume point, and a one-cycle strobe tells the backup logic that the value is ready to be written to nonvolatile storage. If the memory stage holds a bubble, the nearest valid entry further toward fetch is chosen instead. If there is none, the current fetch PC is chosen. The buffer then freezes. A resume request clears every slot, since the volatile pipeline contents are gone. A countdown then reports the cycles still needed to refill the later stages with re-executed instructions.

Slot indices run from 0 (fetch) to 4 (write-back). Slot 3 is the memory stage.

Top module: `pc_shift_buf`

## Requirements
- R1: After reset, every slot valid bit is 0, backupValid is 0, frozen is 0, refillLeft is 0 and resumePc is 0.
- R2: With no stall, no flush and the buffer running, each slot takes the PC and valid bit of the slot before it on each clock edge. Slot 0 takes fetchPc and fetchValid. The entry that leaves slot 4 is dropped.
- R3: stallVec bit i holds slot i and every slot with a lower index. Slot i+1 receives an invalid entry. Slots above i+1 keep advancing unless a stall bit above them holds them.
- R4: flushVec bit i invalidates the entry that is in slot i at that edge. The entry stays invalid at its next position, whether it moves or is held.
- R5: When pwrDown is sampled while running and slot 3 is valid, resumePc takes the slot-3 PC on that edge.
- R6: When pwrDown is sampled while running and slot 3 is invalid, resumePc takes the PC of the highest-indexed valid slot among 2, 1 and 0. If none of them is valid, it takes fetchPc.
- R7: backupValid is high for exactly the one cycle after the edge that latches resumePc. frozen becomes 1 on that same edge.
- R8: While frozen, slot contents, valid bits, resumePc and refillLeft do not change. fetch, stall, flush and pwrDown inputs have no effect.
- R9: resume sampled while frozen clears every slot valid bit and clears frozen. On the same edge refillLeft loads STAGES-1, which is 4 by default. It then falls by one on each edge until it reaches 0. A power-down latch sets it to 0.
- R10: The resume input has no effect while running, and pwrDown has no effect while frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchPc | input | PC_W | PC of the instruction being fetched |
| fetchValid | input | 1 | fetchPc is a real instruction |
| stallVec | input | STAGES | Per-stage stall, bit 0 = fetch |
| flushVec | input | STAGES | Per-stage flush, bit 0 = fetch |
| pwrDown | input | 1 | Power-down request |
| resume | input | 1 | Power restored, restart request |
| stagePcFlat | output | STAGES*PC_W | Slot PCs, slot s in bits [s*PC_W +: PC_W] |
| stageValid | output | STAGES | Slot valid bits |
| resumePc | output | PC_W | Latched resume address |
| backupValid | output | 1 | One-cycle strobe: resumePc ready to save |
| frozen | output | 1 | Buffer held after backup |
| refillLeft | output | $clog2(STAGES) | Refill cycles still outstanding |

## Verification
The in-RTL assertions check on every cycle that a free-running slot passes its PC forward and that frozen state stays stable. They also check that a latch with a valid memory stage captures that PC, that the backup strobe never lasts two cycles, and that a resume clears the slots and loads the refill count. Only the bench's scenarios can show that the stall and flush combinations produce the right bubbles at the right stage. The same holds for choosing the fallback resume address across every pattern of valid slots, for ignoring inputs while frozen, and for the full refill countdown. The bench sweeps stall and flush patterns against an arithmetic model of the shift. It also performs a power-down for all sixteen validity patterns of slots 0 to 3.

// File: rtl/pcsb_pkg.sv
package pcsb_pkg;
  typedef struct packed {
    logic latch;   // capture resume address, stop shifting
    logic freeze;  // hold everything
    logic clear;   // drop all slot entries
  } pcsbStrobe_t;
endpackage

// File: rtl/pcsb_ctrl.sv
module pcsb_ctrl
  import pcsb_pkg::*;
#(
  parameter int STAGES = 5,
  localparam int CNT_W = $clog2(STAGES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwrDown,
  input  logic             resume,
  output pcsbStrobe_t      strobe,
  output logic             backupValid,
  output logic             frozen,
  output logic [CNT_W-1:0] refillLeft
);
  localparam logic [CNT_W-1:0] REFILL = CNT_W'(STAGES - 1);

  typedef enum logic {RUN, HALT} state_t;
  state_t stateQ;

  always_comb begin
    strobe.latch  = (stateQ == RUN) && pwrDown;
    strobe.clear  = (stateQ == HALT) && resume;
    strobe.freeze = (stateQ == HALT) && !resume;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ      <= RUN;
      backupValid <= 1'b0;
      refillLeft  <= '0;
    end else begin
      backupValid <= strobe.latch;
      if (strobe.latch) begin
        stateQ     <= HALT;
        refillLeft <= '0;
      end else if (strobe.clear) begin
        stateQ     <= RUN;
        refillLeft <= REFILL;
      end else if (stateQ == RUN && refillLeft != '0) begin
        refillLeft <= refillLeft - 1'b1;
      end
    end
  end

  assign frozen = (stateQ == HALT);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    backupValid |=> !backupValid);
  a_r7_latch_freezes: assert property (@(posedge clk) disable iff (!rstN)
    (!frozen && pwrDown) |=> (frozen && backupValid));
  a_r9_refill_load: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && resume) |=> (!frozen && refillLeft == REFILL));
  a_r8_refill_hold: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !resume) |=> $stable(refillLeft));
  a_r10_resume_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!frozen && !pwrDown && refillLeft == '0) |=> (refillLeft == '0 && !frozen));
endmodule

// File: rtl/pcsb_datapath.sv
module pcsb_datapath
  import pcsb_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int STAGES = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pcsbStrobe_t              strobe,
  input  logic [PC_W-1:0]          fetchPc,
  input  logic                     fetchValid,
  input  logic [STAGES-1:0]        stallVec,
  input  logic [STAGES-1:0]        flushVec,
  output logic [STAGES*PC_W-1:0]   stagePcFlat,
  output logic [STAGES-1:0]        stageValid,
  output logic [PC_W-1:0]          resumePc
);
  localparam int MEM_IDX = STAGES - 2;

  logic [PC_W-1:0]   pcQ   [STAGES];
  logic [PC_W-1:0]   pcNxt [STAGES];
  logic [STAGES-1:0] validQ, validNxt, holdEff, srcValid;
  logic [PC_W-1:0]   selPc;
  logic              found;

  // A stall at stage j holds j and every slot toward fetch.
  always_comb begin
    for (int i = 0; i < STAGES; i++) begin
      logic acc;
      acc = 1'b0;
      for (int j = i; j < STAGES; j++) acc = acc | stallVec[j];
      holdEff[i] = acc;
    end
    srcValid = validQ & ~flushVec;
  end

  always_comb begin
    for (int s = 0; s < STAGES; s++) begin
      if (holdEff[s]) begin
        validNxt[s] = srcValid[s];
        pcNxt[s]    = pcQ[s];
      end else if (s == 0) begin
        validNxt[s] = fetchValid;
        pcNxt[s]    = fetchPc;
      end else begin
        validNxt[s] = srcValid[s-1] & ~holdEff[s-1];
        pcNxt[s]    = pcQ[s-1];
      end
    end
  end

  // Resume address: memory stage first, then nearest valid toward fetch.
  always_comb begin
    selPc = fetchPc;
    found = 1'b0;
    for (int i = MEM_IDX; i >= 0; i--) begin
      if (!found && validQ[i]) begin
        selPc = pcQ[i];
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ   <= '0;
      resumePc <= '0;
      for (int s = 0; s < STAGES; s++) pcQ[s] <= '0;
    end else if (strobe.clear) begin
      validQ <= '0;
    end else if (strobe.latch) begin
      resumePc <= selPc;
    end else if (!strobe.freeze) begin
      validQ <= validNxt;
      for (int s = 0; s < STAGES; s++) pcQ[s] <= pcNxt[s];
    end
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_flat
    assign stagePcFlat[s*PC_W +: PC_W] = pcQ[s];
  end
  assign stageValid = validQ;

  logic running;
  assign running = !strobe.latch && !strobe.freeze && !strobe.clear;

  a_r2_slot_advance: assert property (@(posedge clk) disable iff (!rstN)
    (running && stallVec == '0 && flushVec == '0 && validQ[0])
      |=> (stageValid[1] && stagePcFlat[PC_W +: PC_W] == $past(pcQ[0])));
  a_r5_mem_captured: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latch && validQ[MEM_IDX]) |=> (resumePc == $past(pcQ[MEM_IDX])));
  a_r8_frozen_stable: assert property (@(posedge clk) disable iff (!rstN)
    strobe.freeze |=> ($stable(stagePcFlat) && $stable(stageValid) && $stable(resumePc)));
  a_r9_resume_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (stageValid == '0));
  a_r3_stall_bubble: assert property (@(posedge clk) disable iff (!rstN)
    (running && stallVec[0] && stallVec[STAGES-1:1] == '0) |=> !stageValid[1]);
endmodule

// File: rtl/pc_shift_buf.sv
module pc_shift_buf
  import pcsb_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int STAGES = 5,
  localparam int CNT_W = $clog2(STAGES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [PC_W-1:0]        fetchPc,
  input  logic                   fetchValid,
  input  logic [STAGES-1:0]      stallVec,
  input  logic [STAGES-1:0]      flushVec,
  input  logic                   pwrDown,
  input  logic                   resume,
  output logic [STAGES*PC_W-1:0] stagePcFlat,
  output logic [STAGES-1:0]      stageValid,
  output logic [PC_W-1:0]        resumePc,
  output logic                   backupValid,
  output logic                   frozen,
  output logic [CNT_W-1:0]       refillLeft
);
  pcsbStrobe_t strobe;

  pcsb_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .pwrDown(pwrDown), .resume(resume),
    .strobe(strobe), .backupValid(backupValid), .frozen(frozen),
    .refillLeft(refillLeft)
  );

  pcsb_datapath #(.PC_W(PC_W), .STAGES(STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fetchPc(fetchPc),
    .fetchValid(fetchValid), .stallVec(stallVec), .flushVec(flushVec),
    .stagePcFlat(stagePcFlat), .stageValid(stageValid), .resumePc(resumePc)
  );
endmodule

// File: tb/pc_shift_buf_tb.sv
module pc_shift_buf_tb;
  localparam int PC_W = 16;
  localparam int ST   = 5;
  localparam int CW   = $clog2(ST);

  logic clk = 1'b0;
  logic rstN;
  logic [PC_W-1:0] fetchPc;
  logic fetchValid, pwrDown, resume;
  logic [ST-1:0] stallVec, flushVec;
  logic [ST*PC_W-1:0] stagePcFlat;
  logic [ST-1:0] stageValid;
  logic [PC_W-1:0] resumePc;
  logic backupValid, frozen;
  logic [CW-1:0] refillLeft;

  int total = 0;
  int bad = 0;

  // reference state
  logic [PC_W-1:0] mPc [ST];
  logic [ST-1:0] mV;
  logic [PC_W-1:0] mRes;
  logic mFrz, mBv;
  int mRef;

  always #2 clk = ~clk;

  pc_shift_buf #(.PC_W(PC_W), .STAGES(ST)) u_dut (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .fetchValid(fetchValid),
    .stallVec(stallVec), .flushVec(flushVec), .pwrDown(pwrDown), .resume(resume),
    .stagePcFlat(stagePcFlat), .stageValid(stageValid), .resumePc(resumePc),
    .backupValid(backupValid), .frozen(frozen), .refillLeft(refillLeft)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Model the edge from the requirements, using pre-edge state and inputs.
  task automatic model_edge();
    logic [ST-1:0] hold, src, nv;
    logic [PC_W-1:0] np [ST];
    logic [PC_W-1:0] sel;
    logic latch, clr;
    latch = !mFrz && pwrDown;
    clr   = mFrz && resume;
    for (int i = 0; i < ST; i++) begin
      hold[i] = 1'b0;
      for (int j = i; j < ST; j++) if (stallVec[j]) hold[i] = 1'b1;
    end
    src = mV & ~flushVec;
    for (int s = 0; s < ST; s++) begin
      np[s] = mPc[s];
      if (hold[s]) nv[s] = src[s];
      else if (s == 0) begin nv[s] = fetchValid; np[s] = fetchPc; end
      else begin nv[s] = src[s-1] & ~hold[s-1]; np[s] = mPc[s-1]; end
    end
    sel = fetchPc;
    for (int i = 0; i <= ST - 2; i++) if (mV[i]) sel = mPc[i];
    mBv = latch;
    if (clr) begin
      mV = '0; mFrz = 1'b0; mRef = ST - 1;
    end else if (latch) begin
      mRes = sel; mFrz = 1'b1; mRef = 0;
    end else if (!mFrz) begin
      mV = nv;
      for (int s = 0; s < ST; s++) mPc[s] = np[s];
      if (mRef != 0) mRef--;
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " valid"}, 32'(stageValid), 32'(mV));
    for (int s = 0; s < ST; s++)
      if (mV[s]) chk({tag, " pc"}, 32'(stagePcFlat[s*PC_W +: PC_W]), 32'(mPc[s]));
    chk({tag, " backupValid"}, 32'(backupValid), 32'(mBv));
    chk({tag, " frozen"}, 32'(frozen), 32'(mFrz));
    chk({tag, " refill"}, 32'(refillLeft), 32'(mRef));
    chk({tag, " resumePc"}, 32'(resumePc), 32'(mRes));
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    #1;
    compare(tag);
    @(negedge clk);
  endtask

  task automatic idle_in();
    stallVec = '0; flushVec = '0; pwrDown = 1'b0; resume = 1'b0;
  endtask

  initial begin
    #(4ns * 150000);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; fetchPc = '0; fetchValid = 1'b0;
    idle_in();
    mV = '0; mRes = '0; mFrz = 1'b0; mBv = 1'b0; mRef = 0;
    for (int s = 0; s < ST; s++) mPc[s] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 valid", 32'(stageValid), 0);
    chk("R1 backupValid", 32'(backupValid), 0);
    chk("R1 frozen", 32'(frozen), 0);
    chk("R1 refill", 32'(refillLeft), 0);
    chk("R1 resumePc", 32'(resumePc), 0);

    // R2 plain shift: fill the pipe
    for (int c = 0; c < 8; c++) begin
      fetchPc = PC_W'(16'h0100 + 4 * c); fetchValid = 1'b1;
      step("R2");
    end
    // R10 resume while running has no effect
    resume = 1'b1; fetchPc = 16'h0200;
    step("R10 resume running");
    resume = 1'b0;

    // R3 / R4 sweep: every stall pattern, mixed with flush patterns
    for (int c = 0; c < 32 * 6; c++) begin
      fetchPc = PC_W'(16'h1000 + 4 * c);
      fetchValid = (c % 7) != 3;
      stallVec = (c % 2 == 0) ? ST'(c / 6) : '0;
      flushVec = (c % 3 == 1) ? ST'((c * 5) % 32) : '0;
      if (stallVec != '0) step("R3 stall");
      else if (flushVec != '0) step("R4 flush");
      else step("R2 shift");
    end
    idle_in();

    // R5..R9: power-down for each validity pattern of slots 0..3
    for (int m = 0; m < 16; m++) begin
      for (int t = 0; t < ST; t++) begin
        fetchPc = PC_W'(16'h4000 + 16 * m + t);
        fetchValid = (ST - 1 - t <= 3) ? m[ST - 1 - t] : 1'b1;
        step("R2 fill");
      end
      fetchPc = PC_W'(16'hF000 + m); fetchValid = 1'b1; pwrDown = 1'b1;
      if (m[3]) step("R5 latch mem"); else step("R6 latch fallback");
      pwrDown = 1'b0;
      // R7/R8/R10: frozen with noisy inputs
      for (int k = 0; k < 3; k++) begin
        stallVec = ST'(k + 5); flushVec = ST'(m + k); pwrDown = k[0];
        fetchPc = PC_W'(16'hBEEF + k);
        step("R8 frozen");
      end
      idle_in();
      resume = 1'b1;
      step("R9 resume");
      resume = 1'b0;
      for (int k = 0; k < ST; k++) step("R9 refill");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule